// File: doc/BRIEF.md
# Pipelined FM Operator Datapath

This block turns one phase word per clock into one signed operator sample. It serves a time-multiplexed synthesiser in which each clock carries a different voice. A voice comes back only after every other voice has had its turn. Each cycle the block takes a phase, a modulation word and an attenuation word. It forms the modulated phase and folds it onto a quarter sine wave. It looks up a logarithmic sine value and adds the attenuation in the log domain. It then returns to the linear domain through a mantissa approximation and a right shift, and applies the sign last.

Four register stages split this work. The side-band bits (the sign taken from the phase sum, and the integer part of the log value that becomes the shift count) are delayed explicitly so that they meet the mantissa in the right cycle. A valid flag and a voice slot number travel with every sample. An optional delay line on the modulation input lengthens the modulation path by a parameter number of cycles. With six interleaved voices, a depth of six keeps each voice's modulator result in step with its own phase.

The log-sine and exponent tables are small computed approximations rather than exact tables. They keep the ordering properties that matter: the output magnitude never rises as attenuation rises.

Top module: `fmop_datapath`

## Requirements
- R1: The modulated phase is s = (in_phase + m) mod 1024, where m is the modulation word taken through the modulation delay line.
- R2: The quarter index is q = s[7:0] when s[8] is 0, and 255 - s[7:0] when s[8] is 1. With v = 2q+1, e = floor(log2 v) and g = 256*e + (v*256 >> e) - 256, the log-sine value is L = min(2047, 2304 - g).
- R3: The log value is lv = L + in_atten, a 12-bit sum that never wraps.
- R4: The shift count is lv[11:8] and the mantissa is 1023 - 2*lv[7:0]. The magnitude is the mantissa shifted right by the shift count, so it is 0 whenever the shift count is 10 or more.
- R5: When s[9] is 1 the output is the two's-complement negative of the magnitude (11 bits). Otherwise it is the magnitude.
- R6: A sample whose inputs are captured at one rising edge appears on out_valid, out_slot and out_sample after the third rising edge that follows. Its in_valid and in_slot come out unchanged beside it.
- R7: The modulation word added at a given edge is the in_mod value captured MOD_DLY edges earlier (default 6). With MOD_DLY = 0 it is the in_mod of the same edge.
- R8: A cycle with in_valid low gives out_valid low and out_sample 0 at the output time of that cycle.
- R9: Reset gives out_valid 0, out_slot 0 and out_sample 0, and clears the modulation delay line to zero.
- R10: For fixed phase and modulation, a larger attenuation never gives a larger output magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, one voice slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks this cycle as carrying a voice sample |
| in_slot | input | 3 | Voice slot number carried with the sample |
| in_phase | input | 10 | Phase word of this voice |
| in_mod | input | 10 | Modulation word, added after the delay line |
| in_atten | input | 10 | Attenuation in log units, larger is quieter |
| out_valid | output | 1 | Valid flag aligned with out_sample |
| out_slot | output | 3 | Slot number aligned with out_sample |
| out_sample | output | 11 | Signed operator output, two's complement |

## Verification
The assertions check on every clock that the valid flag and slot number come out exactly four edges after they enter. They also check that the stage feeding the output applies the sign it carries, that a shift count of ten or more empties the magnitude, and that an idle stage produces a zero output. The bench's reference model covers what a single-cycle property cannot. It checks the exact arithmetic of the log-sine fold and the exponent stage across the whole phase circle, and the alignment of the delayed modulation word against a model with no delay. It also checks monotonic loudness over full attenuation sweeps at several phases.

// File: rtl/fmop_pkg.sv
package fmop_pkg;

    // Word widths of the datapath
    localparam int PH_W    = 10;
    localparam int QTR_W   = PH_W - 2;
    localparam int ATT_W   = 10;
    localparam int LS_W    = 11;
    localparam int LV_W    = 12;
    localparam int FRAC_W  = QTR_W;
    localparam int EXP_W   = LV_W - FRAC_W;
    localparam int MANT_W  = FRAC_W + 2;
    localparam int OUT_W   = MANT_W + 1;

    // Time multiplexing
    localparam int NUM_SLOTS = 6;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int PIPE_LAT  = 4;
    localparam int LAT_CNT_W = $clog2(PIPE_LAT + 1);

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] slot;
    } tag_t;

    // After the phase adder
    typedef struct packed {
        tag_t             tag;
        logic [PH_W-1:0]  psum;
        logic [ATT_W-1:0] att;
    } stg_a_t;

    // After the log-domain adder; sign in its first delay register
    typedef struct packed {
        tag_t            tag;
        logic            sign;
        logic [LV_W-1:0] lv;
    } stg_b_t;

    // Before the shifter; sign in its second register, shift count in its first
    typedef struct packed {
        tag_t              tag;
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } stg_c_t;

    // Approximate -log2(sin) of a quarter-wave index, in 1/256 units
    function automatic logic [LS_W-1:0] logsin_lookup(input logic [QTR_W-1:0] q);
        logic [QTR_W:0] v;
        logic [QTR_W:0] norm;
        int             msb;
        int             acc;
        v   = {q, 1'b1};
        msb = 0;
        for (int b = 0; b <= QTR_W; b++) begin
            if (v[b]) msb = b;
        end
        norm = v << (QTR_W - msb);
        acc  = (QTR_W + 1) * (1 << FRAC_W)
             - (msb * (1 << FRAC_W) + int'(norm[FRAC_W-1:0]));
        if (acc > (1 << LS_W) - 1) acc = (1 << LS_W) - 1;
        return acc[LS_W-1:0];
    endfunction

    // Linear approximation of 2^(-f/256), scaled to MANT_W bits
    function automatic logic [MANT_W-1:0] exp_mantissa(input logic [FRAC_W-1:0] f);
        return {1'b1, ~f, 1'b1};
    endfunction

endpackage

// File: rtl/fmop_mod_delay.sv
module fmop_mod_delay #(
    parameter int DEPTH = 6,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_bypass
            assign q = d;
        end else begin : g_line
            logic [W-1:0] taps [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= d;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end
            assign q = taps[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/fmop_log_front.sv
module fmop_log_front
    import fmop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tag_t             in_tag,
    input  logic [PH_W-1:0]  phase,
    input  logic [PH_W-1:0]  mod_d,
    input  logic [ATT_W-1:0] att,
    output stg_b_t           b_q
);
    stg_a_t           a_q;
    logic [QTR_W-1:0] qidx;
    logic [LS_W-1:0]  ls_val;
    logic [LV_W-1:0]  lv_sum;

    // Stage A: phase plus modulation, attenuation held alongside
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            a_q.tag  <= in_tag;
            a_q.psum <= phase + mod_d;
            a_q.att  <= att;
        end
    end

    // Quarter-wave fold, log-sine lookup, log-domain attenuation
    always_comb begin
        qidx   = a_q.psum[QTR_W] ? ~a_q.psum[QTR_W-1:0] : a_q.psum[QTR_W-1:0];
        ls_val = logsin_lookup(qidx);
        lv_sum = LV_W'(ls_val) + LV_W'(a_q.att);
    end

    // Stage B: log value, sign enters its delay chain
    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else begin
            b_q.tag  <= a_q.tag;
            b_q.sign <= a_q.psum[PH_W-1];
            b_q.lv   <= lv_sum;
        end
    end

    // R3: the log sum never wraps, so a full-scale attenuation keeps lv at or above it
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (a_q.tag.vld && (a_q.att == {ATT_W{1'b1}})) |=> (b_q.lv >= LV_W'({ATT_W{1'b1}})));

endmodule

// File: rtl/fmop_lin_back.sv
module fmop_lin_back
    import fmop_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  stg_b_t                   b_q,
    output logic                     out_vld,
    output logic [SLOT_W-1:0]        out_slot,
    output logic signed [OUT_W-1:0]  out_sample
);
    stg_c_t                  c_q;
    logic [MANT_W-1:0]       mag;
    logic signed [OUT_W-1:0] signed_mag;

    // Stage C: mantissa from the fraction; integer part and sign delayed to match
    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q.tag  <= b_q.tag;
            c_q.sign <= b_q.sign;
            c_q.expo <= b_q.lv[LV_W-1:FRAC_W];
            c_q.mant <= exp_mantissa(b_q.lv[FRAC_W-1:0]);
        end
    end

    always_comb begin
        mag        = c_q.mant >> c_q.expo;
        signed_mag = $signed({1'b0, mag});
    end

    // Stage D: two's-complement output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld    <= 1'b0;
            out_slot   <= '0;
            out_sample <= '0;
        end else begin
            out_vld  <= c_q.tag.vld;
            out_slot <= c_q.tag.slot;
            if (!c_q.tag.vld)     out_sample <= '0;
            else if (c_q.sign)    out_sample <= -signed_mag;
            else                  out_sample <= signed_mag;
        end
    end

    a_r5_negative_half: assert property (@(posedge clk) disable iff (rst)
        (c_q.tag.vld && c_q.sign && (mag != '0)) |=> (out_sample < 0));

    a_r5_positive_half: assert property (@(posedge clk) disable iff (rst)
        (c_q.tag.vld && !c_q.sign) |=> (out_sample >= 0));

    a_r4_deep_shift_zero: assert property (@(posedge clk) disable iff (rst)
        (c_q.tag.vld && (int'(c_q.expo) >= MANT_W)) |=> (out_sample == 0));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!c_q.tag.vld) |=> (!out_vld && (out_sample == 0)));

endmodule

// File: rtl/fmop_datapath.sv
module fmop_datapath
    import fmop_pkg::*;
#(
    parameter int MOD_DLY = NUM_SLOTS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [SLOT_W-1:0]       in_slot,
    input  logic [PH_W-1:0]         in_phase,
    input  logic [PH_W-1:0]         in_mod,
    input  logic [ATT_W-1:0]        in_atten,
    output logic                    out_valid,
    output logic [SLOT_W-1:0]       out_slot,
    output logic signed [OUT_W-1:0] out_sample
);
    logic [PH_W-1:0] mod_d;
    tag_t            in_tag;
    stg_b_t          b_q;

    assign in_tag.vld  = in_valid;
    assign in_tag.slot = in_slot;

    fmop_mod_delay #(
        .DEPTH (MOD_DLY),
        .W     (PH_W)
    ) u_mod_delay (
        .clk (clk),
        .rst (rst),
        .d   (in_mod),
        .q   (mod_d)
    );

    fmop_log_front u_front (
        .clk    (clk),
        .rst    (rst),
        .in_tag (in_tag),
        .phase  (in_phase),
        .mod_d  (mod_d),
        .att    (in_atten),
        .b_q    (b_q)
    );

    fmop_lin_back u_back (
        .clk        (clk),
        .rst        (rst),
        .b_q        (b_q),
        .out_vld    (out_valid),
        .out_slot   (out_slot),
        .out_sample (out_sample)
    );

    // Edges since reset, saturating once the pipeline holds only post-reset data
    logic [LAT_CNT_W-1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)                                  warm_cnt <= '0;
        else if (int'(warm_cnt) != PIPE_LAT)      warm_cnt <= warm_cnt + 1'b1;
    end

    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (int'(warm_cnt) == PIPE_LAT) |-> (out_valid == $past(in_valid, PIPE_LAT)));

    a_r6_slot_align: assert property (@(posedge clk) disable iff (rst)
        ((int'(warm_cnt) == PIPE_LAT) && out_valid) |-> (out_slot == $past(in_slot, PIPE_LAT)));

    a_r9_cold_idle: assert property (@(posedge clk) disable iff (rst)
        (int'(warm_cnt) < PIPE_LAT - 1) |=> (!out_valid && (out_sample == 0)));

endmodule

// File: tb/tb_fmop_datapath.sv
module tb_fmop_datapath;

    localparam int CLK_P = 10;
    localparam int NSTIM = 3446;
    localparam int LAT   = 4;
    localparam int DLY   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    logic        in_valid;
    logic [2:0]  in_slot;
    logic [9:0]  in_phase, in_mod, in_atten;

    logic               ov_a, ov_b;
    logic [2:0]         os_a, os_b;
    logic signed [10:0] smp_a, smp_b;

    fmop_datapath dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_slot (in_slot),
        .in_phase (in_phase), .in_mod (in_mod), .in_atten (in_atten),
        .out_valid (ov_a), .out_slot (os_a), .out_sample (smp_a)
    );

    fmop_datapath #(.MOD_DLY(0)) dut_nd (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_slot (in_slot),
        .in_phase (in_phase), .in_mod (in_mod), .in_atten (in_atten),
        .out_valid (ov_b), .out_slot (os_b), .out_sample (smp_b)
    );

    int    st_v [NSTIM];
    int    st_slot [NSTIM];
    int    st_ph [NSTIM];
    int    st_md [NSTIM];
    int    st_at [NSTIM];
    int    st_mono [NSTIM];
    string st_tag [NSTIM];

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int prev_a = 0;
    int prev_b = 0;

    // Behavioural model of R1..R5
    function automatic int ref_out(int ph, int md, int at);
        int s, q, v, e, g, l, lv, mant, sh, mag;
        s = (ph + md) % 1024;
        q = ((s / 256) % 2 == 1) ? 255 - (s % 256) : (s % 256);
        v = 2 * q + 1;
        e = 0;
        while ((2 ** (e + 1)) <= v) e++;
        g = 256 * e + (v * 256) / (2 ** e) - 256;
        l = 2304 - g;
        if (l > 2047) l = 2047;
        lv   = l + at;
        mant = 1023 - 2 * (lv % 256);
        sh   = lv / 256;
        mag  = (sh >= 31) ? 0 : mant / (2 ** sh);
        return (s >= 512) ? -mag : mag;
    endfunction

    function automatic int md_at(int k);
        return (k < 0) ? 0 : st_md[k];
    endfunction

    task automatic check_one(string who, int k, int dly, logic ov, logic [2:0] os,
                             logic signed [10:0] smp, inout int prev_mag);
        int    expv, exps, expd, act, mag;
        string tag;
        expv = (k >= 0) ? st_v[k] : 0;
        exps = (expv != 0) ? st_slot[k] : 0;
        expd = (expv != 0) ? ref_out(st_ph[k], md_at(k - dly), st_at[k]) : 0;
        act  = int'(smp);
        if (k < 0)                                         tag = "R9";
        else if (expv == 0)                                tag = "R8";
        else if (expd < 0)                                 tag = "R5";
        else if (dly != 0 && md_at(k - dly) != md_at(k))   tag = "R7";
        else                                               tag = st_tag[k];
        // R6: valid and slot alignment
        n_chk++;
        if ((ov !== (expv != 0)) || ((expv != 0) && (os !== 3'(exps)))) begin
            n_fail++;
            $display("FAIL R6 %s idx %0d: valid/slot actual %b/%0d expected %0d/%0d",
                     who, k, ov, os, expv, exps);
        end
        n_chk++;
        if (act != expd) begin
            n_fail++;
            $display("FAIL %s %s idx %0d: sample actual %0d expected %0d", tag, who, k, act, expd);
        end
        // R10: monotonic loudness along an attenuation sweep
        mag = (act < 0) ? -act : act;
        if (k >= 0 && expv != 0 && st_mono[k] != 0) begin
            n_chk++;
            if (mag > prev_mag) begin
                n_fail++;
                $display("FAIL R10 %s idx %0d: magnitude actual %0d expected at most %0d",
                         who, k, mag, prev_mag);
            end
        end
        if (expv != 0) prev_mag = mag;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int i = 0; i < NSTIM; i++) begin
            int j;
            st_v[i] = 1; st_slot[i] = i % 6; st_md[i] = 0; st_at[i] = 0; st_mono[i] = 0;
            if (i < 300) begin
                st_ph[i] = (i * 37) % 1024;            // R2 sweep of the circle
                st_tag[i] = "R2";
            end else if (i < 1300) begin
                st_ph[i] = int'($urandom_range(1023, 0));
                st_md[i] = int'($urandom_range(1023, 0));
                st_at[i] = int'($urandom_range(1023, 0));
                st_tag[i] = "R1";
            end else if (i < 1800) begin
                st_v[i]  = ($urandom_range(2, 0) != 0) ? 1 : 0;
                st_ph[i] = int'($urandom_range(1023, 0));
                st_md[i] = int'($urandom_range(1023, 0));
                st_at[i] = int'($urandom_range(1023, 0));
                st_tag[i] = "R3";
            end else if (i < 1900) begin
                j = i - 1800;                            // R4 corners
                case (j % 8)
                    0: st_ph[i] = 0;    1: st_ph[i] = 255;
                    2: st_ph[i] = 256;  3: st_ph[i] = 511;
                    4: st_ph[i] = 512;  5: st_ph[i] = 767;
                    6: st_ph[i] = 768;  default: st_ph[i] = 1023;
                endcase
                st_at[i] = ((j / 8) % 3 == 0) ? 0 : (((j / 8) % 3 == 1) ? 1023 : 300);
                st_md[i] = (j >= 40 && i < 1890) ? (j * 97) % 1024 : 0;
                st_tag[i] = "R4";
            end else if (i < 1900 + 1536) begin
                j = i - 1900;                            // R10 sweeps
                st_ph[i]   = (j / 512 == 0) ? 100 : ((j / 512 == 1) ? 300 : 700);
                st_at[i]   = 2 * (j % 512);
                st_mono[i] = ((j % 512) != 0) ? 1 : 0;
                st_tag[i]  = "R3";
            end else begin
                st_v[i] = 0; st_ph[i] = 0;
                st_tag[i] = "R8";
            end
        end

        in_valid = 1'b0; in_slot = '0; in_phase = '0; in_mod = '0; in_atten = '0;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NSTIM + LAT; i++) begin
            check_one("dut", i - LAT, DLY, ov_a, os_a, smp_a, prev_a);
            check_one("dut_nd", i - LAT, 0, ov_b, os_b, smp_b, prev_b);
            if (i < NSTIM) begin
                in_valid = (st_v[i] != 0);
                in_slot  = 3'(st_slot[i]);
                in_phase = 10'(st_ph[i]);
                in_mod   = 10'(st_md[i]);
                in_atten = 10'(st_at[i]);
            end else begin
                in_valid = 1'b0; in_slot = '0; in_phase = '0; in_mod = '0; in_atten = '0;
            end
            @(negedge clk);
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog: run did not complete, actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule